// File: doc/BRIEF.md
# Read-Only Slot Write Sequencer

This block sits on a memory slot that only has read cycles and gives the host a way to perform 32-bit register writes. It watches the slot address bus and the active-low read strobe, which combines chip select and output enable. The address space is split on its top bit. In the lower half the block stays silent and the flash devices answer. The upper half belongs to the block: one offset arms a write sequence, one offset returns status, and a payload window turns the low address bits of each read into payload.

A write runs as follows. The host reads the arm offset, then reads window locations whose low address bits spell out first the 32-bit target address and then the 32-bit data word, most significant part first. When the last part has been captured, the block raises a request on an internal request/acknowledge port. The host polls the status word until the done bit appears.

In the narrow mode each window read carries one byte, so one write costs nine reads. A parameter selects a wide mode in which each read carries sixteen bits and a write costs five reads.

Top module: `romslot_wr_seq`

## Requirements
- R1: A read whose address top bit is 0 never enables the block's data driver. While the driver enable `rd_oe` is low, `rd_data` is all zeros.
- R2: The strobe passes through a two-flop synchronizer. Each low period of the strobe counts as exactly one read, however many clock cycles it lasts, and the address is taken when that read is detected.
- R3: A read at upper-half offset 0x000 arms the sequencer. It discards any partial sequence and restarts collection from the first part.
- R4: In narrow mode the window is upper-half offsets 0x100 to 0x1FF, and the low 8 address bits of each window read are one payload byte. The first four bytes form the target address and the next four the data word, both most significant byte first. The request is issued after the eighth byte.
- R5: In wide mode the window is upper-half offsets 0x10000 to 0x1FFFF, and each read carries the low 16 address bits. Two reads form the address and two form the data, most significant half first.
- R6: Window reads made while not armed are ignored. Reads of the status offset or of other upper-half offsets leave a sequence in progress unchanged.
- R7: `wr_req` stays high with `wr_addr` and `wr_data` stable until a cycle with `wr_ack` high. Status bit 0 (busy) is 1 for exactly that time.
- R8: Status bit 1 (done) is set when the request is acknowledged. It stays set until the next read of the arm offset, and it is never 1 while busy is 1.
- R9: A read of upper-half offset 0x004 returns busy in bit 0 and done in bit 1, with all other bits zero. Window reads and other upper-half reads return zero.
- R10: A sequence that completes while an earlier request is still unacknowledged is dropped and issues no request.
- R11: `rd_oe` is high only while the synchronized strobe is asserted and the address top bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_addr | input | ADDR_W | Slot byte address; top bit selects the block's half |
| slot_strobe_n | input | 1 | Combined chip select / output enable, active low, asynchronous |
| rd_data | output | DATA_W | Read data for the slot data pads |
| rd_oe | output | 1 | Pad driver enable; pads are high impedance when low |
| wr_req | output | 1 | Internal write request |
| wr_addr | output | 32 | Target address of the pending write |
| wr_data | output | 32 | Data word of the pending write |
| wr_ack | input | 1 | Acknowledge from the internal target |

## Verification
The embedded assertions check these rules on every cycle: each strobe produces a single read event; the collection counter stays in range; the request stays stable until it is acknowledged; a request starts only from a completed sequence; busy and done are never both set; and data is zero whenever the driver is off. Only the bench scenarios can show the payload order and its assembly into address and data in both modes, restarts on a repeated arm read, the ignoring of unarmed or foreign reads, the dropping of a sequence that completes while busy, and the status values the host sees at each stage.

// File: rtl/romslot_wr_pkg.sv
package romslot_wr_pkg;
  localparam int unsigned PAYLOAD_W = 64;
  localparam int unsigned ST_BUSY   = 0;
  localparam int unsigned ST_DONE   = 1;

  typedef struct packed {
    logic upper;
    logic arm_hit;
    logic stat_hit;
    logic win_hit;
  } slot_hit_t;
endpackage

// File: rtl/romslot_strobe_sync.sv
module romslot_strobe_sync (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic active,
  output logic read_evt
);
  logic s1_n, s2_n, s3_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_n <= 1'b1;
      s2_n <= 1'b1;
      s3_n <= 1'b1;
    end else begin
      s1_n <= strobe_n;
      s2_n <= s1_n;
      s3_n <= s2_n;
    end
  end

  assign active   = ~s2_n;
  assign read_evt = s3_n & ~s2_n;

  a_r2_single_event: assert property (@(posedge clk) disable iff (rst)
    read_evt |=> !read_evt);
endmodule

// File: rtl/romslot_addr_decode.sv
module romslot_addr_decode
  import romslot_wr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 23,
  parameter int unsigned CHUNK_W  = 8,
  parameter int unsigned ARM_OFS  = 32'h0,
  parameter int unsigned STAT_OFS = 32'h4
) (
  input  logic [ADDR_W-1:0]  addr,
  output slot_hit_t          hit,
  output logic [CHUNK_W-1:0] payload
);
  localparam int unsigned OFS_W    = ADDR_W - 1;
  localparam int unsigned WIN_BASE = 1 << CHUNK_W;

  logic [OFS_W-1:0] ofs;
  assign ofs = addr[OFS_W-1:0];

  always_comb begin
    hit.upper    = addr[ADDR_W-1];
    hit.arm_hit  = hit.upper && (ofs == OFS_W'(ARM_OFS));
    hit.stat_hit = hit.upper && (ofs == OFS_W'(STAT_OFS));
    hit.win_hit  = hit.upper && ((ofs >> CHUNK_W) == OFS_W'(WIN_BASE >> CHUNK_W));
    payload      = ofs[CHUNK_W-1:0];
  end
endmodule

// File: rtl/romslot_collector.sv
module romslot_collector
  import romslot_wr_pkg::*;
#(
  parameter int unsigned CHUNK_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 read_evt,
  input  slot_hit_t            hit,
  input  logic [CHUNK_W-1:0]   payload,
  output logic                 fire,
  output logic [PAYLOAD_W-1:0] word
);
  localparam int unsigned STEPS = PAYLOAD_W / CHUNK_W;
  localparam int unsigned CW    = $clog2(STEPS + 1);

  logic [CW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
      fire  <= 1'b0;
      word  <= '0;
    end else begin
      fire <= 1'b0;
      if (read_evt && hit.arm_hit) begin
        armed <= 1'b1;
        cnt   <= '0;
        word  <= '0;
      end else if (read_evt && hit.win_hit && armed) begin
        word <= {word[PAYLOAD_W-CHUNK_W-1:0], payload};
        if (cnt == CW'(STEPS - 1)) begin
          cnt   <= '0;
          armed <= 1'b0;
          fire  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(STEPS));
  a_r3_idle_count: assert property (@(posedge clk) disable iff (rst)
    !armed |-> cnt == '0);
endmodule

// File: rtl/romslot_write_port.sv
module romslot_write_port
  import romslot_wr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic [PAYLOAD_W-1:0] word,
  input  logic                 clr_done,
  input  logic                 ack,
  output logic                 req,
  output logic [31:0]          req_addr,
  output logic [31:0]          req_data,
  output logic                 done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req      <= 1'b0;
      req_addr <= '0;
      req_data <= '0;
      done     <= 1'b0;
    end else begin
      if (clr_done) done <= 1'b0;
      if (fire && !req) begin
        req      <= 1'b1;
        req_addr <= word[63:32];
        req_data <= word[31:0];
        done     <= 1'b0;
      end else if (req && ack) begin
        req  <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> (req && $stable(req_addr) && $stable(req_data)));
  a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    req |-> !done);
  a_r10_req_from_fire: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> $past(fire));
endmodule

// File: rtl/romslot_wr_seq.sv
module romslot_wr_seq
  import romslot_wr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 23,
  parameter int unsigned DATA_W    = 32,
  parameter bit          WIDE_MODE = 1'b0,
  parameter int unsigned ARM_OFS   = 32'h0,
  parameter int unsigned STAT_OFS  = 32'h4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic              slot_strobe_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe,
  output logic              wr_req,
  output logic [31:0]       wr_addr,
  output logic [31:0]       wr_data,
  input  logic              wr_ack
);
  localparam int unsigned CHUNK_W = WIDE_MODE ? 16 : 8;

  logic                 active, read_evt, fire, done;
  slot_hit_t            hit;
  logic [CHUNK_W-1:0]   payload;
  logic [PAYLOAD_W-1:0] word;

  romslot_strobe_sync u_sync (
    .clk(clk), .rst(rst), .strobe_n(slot_strobe_n),
    .active(active), .read_evt(read_evt)
  );

  romslot_addr_decode #(
    .ADDR_W(ADDR_W), .CHUNK_W(CHUNK_W), .ARM_OFS(ARM_OFS), .STAT_OFS(STAT_OFS)
  ) u_dec (
    .addr(slot_addr), .hit(hit), .payload(payload)
  );

  romslot_collector #(.CHUNK_W(CHUNK_W)) u_col (
    .clk(clk), .rst(rst), .read_evt(read_evt), .hit(hit),
    .payload(payload), .fire(fire), .word(word)
  );

  romslot_write_port u_port (
    .clk(clk), .rst(rst), .fire(fire), .word(word),
    .clr_done(read_evt && hit.arm_hit), .ack(wr_ack),
    .req(wr_req), .req_addr(wr_addr), .req_data(wr_data), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_oe   <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_oe   <= active && hit.upper;
      rd_data <= '0;
      if (active && hit.stat_hit) begin
        rd_data[ST_BUSY] <= wr_req;
        rd_data[ST_DONE] <= done;
      end
    end
  end

  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !rd_oe |-> rd_data == '0);
  a_r9_status_bits_only: assert property (@(posedge clk) disable iff (rst)
    (rd_data >> 2) == '0);
endmodule

// File: tb/romslot_wr_seq_test.sv
module romslot_wr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] a_n = '0, a_w = '0;
  logic s_n = 1'b1, s_w = 1'b1;
  logic ack_n = 1'b0, ack_w = 1'b0;
  logic [31:0] d_n, d_w, wa_n, wd_n, wa_w, wd_w;
  logic oe_n, oe_w, req_n, req_w;

  romslot_wr_seq #(.WIDE_MODE(1'b0)) uut (
    .clk(clk), .rst(rst), .slot_addr(a_n), .slot_strobe_n(s_n),
    .rd_data(d_n), .rd_oe(oe_n), .wr_req(req_n), .wr_addr(wa_n),
    .wr_data(wd_n), .wr_ack(ack_n));

  romslot_wr_seq #(.WIDE_MODE(1'b1)) uut_wide (
    .clk(clk), .rst(rst), .slot_addr(a_w), .slot_strobe_n(s_w),
    .rd_data(d_w), .rd_oe(oe_w), .wr_req(req_w), .wr_addr(wa_w),
    .wr_data(wd_w), .wr_ack(ack_w));

  int total = 0, bad = 0;
  bit ack_hold = 1'b0;
  logic [63:0] q_n[$], q_w[$];

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic bus_read(input bit w, input logic [AW-1:0] a, input int hold,
                          output logic [31:0] d, output logic oe);
    @(negedge clk);
    if (w) begin a_w = a; s_w = 1'b0; end else begin a_n = a; s_n = 1'b0; end
    repeat (hold) @(negedge clk);
    d  = w ? d_w : d_n;
    oe = w ? oe_w : oe_n;
    if (w) s_w = 1'b1; else s_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [AW-1:0] up(input logic [21:0] ofs);
    return {1'b1, ofs};
  endfunction

  task automatic rd_status(input bit w, output logic [31:0] d);
    logic oe;
    bus_read(w, up(22'h4), 5, d, oe);
  endtask

  // Driver: pushes expected item, then issues the read run.
  task automatic do_write(input bit w, input logic [31:0] ad, input logic [31:0] dt,
                          input bit expect_req);
    logic [63:0] wd;
    logic [31:0] d;
    logic oe;
    int cw, steps;
    wd = {ad, dt};
    cw = w ? 16 : 8;
    steps = 64 / cw;
    if (expect_req) begin
      if (w) q_w.push_back(wd); else q_n.push_back(wd);
    end
    bus_read(w, up(22'h0), 5, d, oe);
    for (int k = 0; k < steps; k++) begin
      logic [15:0] part;
      part = 16'((wd >> (64 - cw*(k+1))) & ((64'd1 << cw) - 1));
      bus_read(w, up(w ? (22'h10000 | 22'(part)) : (22'h100 | 22'(part))), 5, d, oe);
    end
  endtask

  // Monitors: pop expected items and compare as requests appear.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && req_n) begin
        if (q_n.size() == 0) chk(1'b0, "R6/R10 unexpected request", {wa_n, wd_n}, 64'h0);
        else begin
          logic [63:0] e;
          e = q_n.pop_front();
          chk({wa_n, wd_n} == e, "R4 narrow request", {wa_n, wd_n}, e);
        end
        wait (!ack_hold);
        repeat (3) @(negedge clk);
        ack_n = 1'b1;
        @(negedge clk);
        ack_n = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (!rst && req_w) begin
        if (q_w.size() == 0) chk(1'b0, "R5 unexpected request", {wa_w, wd_w}, 64'h0);
        else begin
          logic [63:0] e;
          e = q_w.pop_front();
          chk({wa_w, wd_w} == e, "R5 wide request", {wa_w, wd_w}, e);
        end
        wait (!ack_hold);
        repeat (3) @(negedge clk);
        ack_w = 1'b1;
        @(negedge clk);
        ack_w = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic oe;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!oe_n && !req_n && d_n == 0, "R1 reset state", {oe_n, req_n, d_n}, 0);

    rd_status(1'b0, d);
    chk(d == 32'h0, "R9 status after reset", d, 0);

    // R11/R1: lower half read keeps the driver off
    bus_read(1'b0, 23'h000104, 5, d, oe);
    chk(!oe && d == 0, "R1 lower half not driven", {oe, d}, 0);
    @(negedge clk);
    chk(!oe_n, "R11 idle driver off", oe_n, 0);

    // R9: window read returns zero with driver on
    bus_read(1'b0, up(22'h1AB), 5, d, oe);
    chk(oe && d == 0, "R9 window read value", {oe, d}, 64'h1_0000_0000);

    // R4 basic narrow write, R7 busy while pending
    ack_hold = 1'b1;
    do_write(1'b0, 32'hABCDEF00, 32'h12345678, 1'b1);
    rd_status(1'b0, d);
    chk(d == 32'h1, "R7 busy while pending", d, 1);
    chk(req_n && wa_n == 32'hABCDEF00, "R7 request held", wa_n, 32'hABCDEF00);

    // R10: sequence completed while busy is dropped
    do_write(1'b0, 32'h11111111, 32'h22222222, 1'b0);
    ack_hold = 1'b0;
    repeat (30) @(negedge clk);
    rd_status(1'b0, d);
    chk(d == 32'h2, "R8 done after ack", d, 2);
    chk(q_n.size() == 0, "R10 only first request issued", q_n.size(), 0);

    // R6: window reads while not armed are ignored, done kept
    for (int k = 0; k < 8; k++) bus_read(1'b0, up(22'h100 | 22'(k)), 5, d, oe);
    repeat (10) @(negedge clk);
    chk(!req_n, "R6 unarmed window ignored", req_n, 0);
    rd_status(1'b0, d);
    chk(d == 32'h2, "R8 done holds until arm read", d, 2);

    // R3: restart on repeated arm read; R8 done cleared by arm read
    bus_read(1'b0, up(22'h0), 5, d, oe);
    rd_status(1'b0, d);
    chk(d == 32'h0, "R8 done cleared by arm read", d, 0);
    bus_read(1'b0, up(22'h1DE), 5, d, oe);
    bus_read(1'b0, up(22'h1AD), 5, d, oe);
    bus_read(1'b0, up(22'h1BE), 5, d, oe);
    do_write(1'b0, 32'hCAFE0001, 32'h00FF00FF, 1'b1);
    repeat (20) @(negedge clk);
    chk(q_n.size() == 0, "R3 restart delivered", q_n.size(), 0);

    // R6: status and foreign upper reads mid-sequence; R2: long strobe counts once
    q_n.push_back({32'h01020304, 32'h0A0B0C0D});
    bus_read(1'b0, up(22'h0), 5, d, oe);
    bus_read(1'b0, up(22'h101), 5, d, oe);
    bus_read(1'b0, up(22'h102), 40, d, oe);
    rd_status(1'b0, d);
    bus_read(1'b0, up(22'h3000), 5, d, oe);
    chk(oe && d == 0, "R9 other upper read zero", {oe, d}, 64'h1_0000_0000);
    bus_read(1'b0, 23'h000105, 5, d, oe);
    foreach (d_arr[i]) ;
    bus_read(1'b0, up(22'h103), 5, d, oe);
    bus_read(1'b0, up(22'h104), 5, d, oe);
    bus_read(1'b0, up(22'h10A), 5, d, oe);
    bus_read(1'b0, up(22'h10B), 5, d, oe);
    bus_read(1'b0, up(22'h10C), 5, d, oe);
    bus_read(1'b0, up(22'h10D), 5, d, oe);
    repeat (20) @(negedge clk);
    chk(q_n.size() == 0, "R2/R6 long strobe and foreign reads", q_n.size(), 0);

    // R5: wide mode, five reads per write
    do_write(1'b1, 32'hDEADBEEF, 32'h0BADF00D, 1'b1);
    repeat (20) @(negedge clk);
    chk(q_w.size() == 0, "R5 wide write delivered", q_w.size(), 0);
    rd_status(1'b1, d);
    chk(d == 32'h2, "R5 wide done status", d, 2);
    bus_read(1'b1, 23'h010000, 5, d, oe);
    chk(!oe && d == 0, "R11 wide lower half off", {oe, d}, 0);

    repeat (10) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int d_arr[1];
endmodule